// File: doc/BRIEF.md
# Conditional Skip Unit

This block resolves conditional relative skips for a stack-oriented instruction stream. The fetch logic issues one skip at a time with its opcode, its inline signed word count, the address of the skip instruction, the two topmost parameter-stack cells and the carry flag. One cycle later the unit returns the next instruction address, whether the skip was taken, how many stack cells the stack logic must discard, and an illegal flag for a malformed count.

The opcode has five bits. Bit 4 selects the direction (0 forward, 1 backward), and bits 3:0 select the condition. The conditions are 0 carry set, 1 carry clear, 2 top cell non-zero, 3 top cell zero, 4 top cell negative, 5 top cell positive, 6 equal, 7 less, 8 less-or-equal, 9 greater and 10 greater-or-equal. Codes 11 to 15 are undefined. Each skip occupies two words: the opcode word and its count word. The fall-through address is therefore the skip address plus two.

Top module: `skip_unit`

## Requirements
- R1: After reset, the outputs `out_valid`, `taken`, `illegal` and `pop_cnt` are 0, and `next_ip` is 0.
- R2: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high. While no skip is issued, `next_ip`, `taken`, `pop_cnt` and `illegal` keep their last values.
- R3: Condition codes 0 (carry set) and 1 (carry clear) are decided by `carry` alone and give `pop_cnt` = 0.
- R4: Condition codes 2 (non-zero) and 3 (zero) test `tos` and give `pop_cnt` = 1.
- R5: Condition codes 4 (negative) and 5 (positive) test only bit DATA_W-1 of `tos`: set means negative, clear means positive. Both give `pop_cnt` = 1.
- R6: Condition codes 6 to 10 compare `nos` against `tos` as signed DATA_W-bit integers, with `nos` on the left of the operator (=, <, <=, >, >=). They give `pop_cnt` = 2.
- R7: When a skip is taken, `next_ip` = `ip` + 2 + `count` (signed), modulo 2^ADDR_W.
- R8: When a legal skip is not taken, `next_ip` = `ip` + 2 and `pop_cnt` still takes the value of its condition class.
- R9: A forward skip (opcode bit 4 = 0) is legal only for `count` from 1 to MAX_SKIP (65536). Any other count sets `illegal`.
- R10: A backward skip (opcode bit 4 = 1) is legal only for `count` from -MAX_SKIP to -1. Any other count sets `illegal`.
- R11: Condition codes 11 to 15 set `illegal`. Whenever `illegal` is 1, `taken` = 0, `pop_cnt` = 0 and `next_ip` = `ip` + 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for one skip |
| opcode | input | 5 | Bit 4 is the direction, bits 3:0 the condition code |
| count | input | CNT_W (18) | Signed inline word count |
| ip | input | ADDR_W (32) | Address of the skip instruction |
| tos | input | DATA_W (32) | Top stack cell |
| nos | input | DATA_W (32) | Second stack cell |
| carry | input | 1 | Carry flag |
| out_valid | output | 1 | Result strobe |
| next_ip | output | ADDR_W (32) | Address to fetch next |
| taken | output | 1 | The skip was taken |
| pop_cnt | output | 2 | Stack cells to discard |
| illegal | output | 1 | Malformed count or undefined condition |

## Verification
Two things can happen in the same result cycle. A skip can be taken while stack cells are popped, and a true condition can meet an out-of-range count, where rejection must override both the jump and the pop. The bench provokes both by sweeping every opcode against every pair drawn from a set of boundary operand values, both carry levels and a count list. The count list covers both range ends, zero and one step past each end. An arithmetic model in the bench predicts the address, the taken flag, the pop count and the illegal flag for every issue, and each result is compared in full.

// File: rtl/skip_pkg.sv
package skip_pkg;
  typedef enum logic [3:0] {
    CND_CY_SET  = 4'd0,
    CND_CY_CLR  = 4'd1,
    CND_NONZERO = 4'd2,
    CND_ZERO    = 4'd3,
    CND_NEG     = 4'd4,
    CND_POS     = 4'd5,
    CND_EQ      = 4'd6,
    CND_LT      = 4'd7,
    CND_LE      = 4'd8,
    CND_GT      = 4'd9,
    CND_GE      = 4'd10
  } cond_e;

  localparam int OP_W     = 5;
  localparam int OP_DIR_B = 4;
  localparam int POP_W    = 2;

  typedef struct packed {
    logic             hit;
    logic             known;
    logic [POP_W-1:0] pops;
  } cond_res_t;
endpackage

// File: rtl/skip_cond_eval.sv
module skip_cond_eval
  import skip_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        cond,
  input  logic [DATA_W-1:0] tos,
  input  logic [DATA_W-1:0] nos,
  input  logic              carry,
  output cond_res_t         res
);
  logic sgn_lt, sgn_eq;

  assign sgn_lt = $signed(nos) < $signed(tos);
  assign sgn_eq = nos == tos;

  always_comb begin
    res = '{hit: 1'b0, known: 1'b1, pops: 2'd0};
    case (cond)
      CND_CY_SET:  begin res.hit = carry;              res.pops = 2'd0; end
      CND_CY_CLR:  begin res.hit = !carry;             res.pops = 2'd0; end
      CND_NONZERO: begin res.hit = |tos;               res.pops = 2'd1; end
      CND_ZERO:    begin res.hit = ~|tos;              res.pops = 2'd1; end
      CND_NEG:     begin res.hit = tos[DATA_W-1];      res.pops = 2'd1; end
      CND_POS:     begin res.hit = !tos[DATA_W-1];     res.pops = 2'd1; end
      CND_EQ:      begin res.hit = sgn_eq;             res.pops = 2'd2; end
      CND_LT:      begin res.hit = sgn_lt;             res.pops = 2'd2; end
      CND_LE:      begin res.hit = sgn_lt || sgn_eq;   res.pops = 2'd2; end
      CND_GT:      begin res.hit = !sgn_lt && !sgn_eq; res.pops = 2'd2; end
      CND_GE:      begin res.hit = !sgn_lt;            res.pops = 2'd2; end
      default:     begin res.known = 1'b0; end
    endcase
  end

  always_comb begin
    if (!res.known) assert (res.pops == 2'd0 && !res.hit)
      else $error("p_undef_quiet_r11");
  end
endmodule

// File: rtl/skip_range_chk.sv
module skip_range_chk #(
  parameter int CNT_W    = 18,
  parameter int MAX_SKIP = 65536
) (
  input  logic [CNT_W-1:0] count,
  input  logic             backward,
  output logic             ok
);
  localparam int EXT_W = CNT_W + 1;
  localparam logic signed [EXT_W-1:0] LIM = EXT_W'(MAX_SKIP);

  logic signed [EXT_W-1:0] cext;
  logic fwd_ok, bwd_ok;

  assign cext   = $signed({count[CNT_W-1], count});
  assign fwd_ok = (cext > 0) && (cext <= LIM);
  assign bwd_ok = (cext < 0) && (cext >= -LIM);
  assign ok     = backward ? bwd_ok : fwd_ok;
endmodule

// File: rtl/skip_target.sv
module skip_target #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 18,
  parameter int INSTR_WORDS = 2
) (
  input  logic [ADDR_W-1:0] ip,
  input  logic [CNT_W-1:0]  count,
  input  logic              take,
  output logic [ADDR_W-1:0] target
);
  logic [ADDR_W-1:0] fall, offs;

  generate
    if (ADDR_W > CNT_W) begin : g_sext
      assign offs = {{(ADDR_W-CNT_W){count[CNT_W-1]}}, count};
    end else begin : g_trunc
      assign offs = count[ADDR_W-1:0];
    end
  endgenerate

  assign fall   = ip + ADDR_W'(INSTR_WORDS);
  assign target = take ? fall + offs : fall;
endmodule

// File: rtl/skip_unit.sv
module skip_unit
  import skip_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 18,
  parameter int MAX_SKIP    = 65536,
  parameter int INSTR_WORDS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [4:0]        opcode,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] ip,
  input  logic [DATA_W-1:0] tos,
  input  logic [DATA_W-1:0] nos,
  input  logic              carry,
  output logic              out_valid,
  output logic [ADDR_W-1:0] next_ip,
  output logic              taken,
  output logic [1:0]        pop_cnt,
  output logic              illegal
);
  cond_res_t         cres;
  logic              rng_ok, legal, take_c;
  logic [ADDR_W-1:0] tgt_c;
  logic [ADDR_W-1:0] ip_q;
  logic [3:0]        cond_q;

  skip_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .cond(opcode[3:0]), .tos(tos), .nos(nos), .carry(carry), .res(cres)
  );

  skip_range_chk #(.CNT_W(CNT_W), .MAX_SKIP(MAX_SKIP)) u_rng (
    .count(count), .backward(opcode[OP_DIR_B]), .ok(rng_ok)
  );

  assign legal  = rng_ok && cres.known;
  assign take_c = legal && cres.hit;

  skip_target #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .INSTR_WORDS(INSTR_WORDS)) u_tgt (
    .ip(ip), .count(count), .take(take_c), .target(tgt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      next_ip   <= '0;
      taken     <= 1'b0;
      pop_cnt   <= '0;
      illegal   <= 1'b0;
      ip_q      <= '0;
      cond_q    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        next_ip <= tgt_c;
        taken   <= take_c;
        pop_cnt <= legal ? cres.pops : 2'd0;
        illegal <= !legal;
        ip_q    <= ip;
        cond_q  <= opcode[3:0];
      end
    end
  end

  // R2: one-cycle result strobe
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid) else $error("p_latency_r2");
  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid) else $error("p_quiet_r2");
  // R3: carry class pops nothing
  p_carry_pop_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !illegal && cond_q <= 4'd1) |-> pop_cnt == 2'd0) else $error("p_carry_pop_r3");
  // R4: single-cell tests pop one
  p_one_pop_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !illegal && (cond_q == 4'd2 || cond_q == 4'd3)) |-> pop_cnt == 2'd1)
    else $error("p_one_pop_r4");
  // R6: compare class pops two
  p_cmp_pop_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !illegal && cond_q >= 4'd6) |-> pop_cnt == 2'd2) else $error("p_cmp_pop_r6");
  // R8: fall-through address
  p_fall_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !taken) |-> next_ip == ip_q + ADDR_W'(INSTR_WORDS)) else $error("p_fall_r8");
  // R11: rejection overrides jump and pop
  p_reject_r11: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!taken && pop_cnt == 2'd0)) else $error("p_reject_r11");
endmodule

// File: tb/sim_skip_unit.sv
module sim_skip_unit;
  localparam int CLK_P = 10;
  localparam int MAXS  = 65536;

  logic clk = 0, rst = 1, in_valid = 0, carry = 0;
  logic [4:0] opcode = '0;
  logic [17:0] count = '0;
  logic [31:0] ip = '0, tos = '0, nos = '0;
  logic out_valid, taken, illegal;
  logic [31:0] next_ip;
  logic [1:0] pop_cnt;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  skip_unit u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .count(count),
    .ip(ip), .tos(tos), .nos(nos), .carry(carry), .out_valid(out_valid), .next_ip(next_ip),
    .taken(taken), .pop_cnt(pop_cnt), .illegal(illegal));

  function automatic logic [31:0] pickv(int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      default: return 32'h0000_0005;
    endcase
  endfunction

  function automatic int pickc(int i);
    case (i)
      0: return 1;
      1: return MAXS;
      2: return -1;
      3: return -MAXS;
      4: return 0;
      5: return MAXS + 1;
      6: return -MAXS - 1;
      7: return 300;
      default: return -7;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue_and_check(logic [4:0] op, int c, logic [31:0] a, logic [31:0] t,
                                 logic [31:0] n, logic cy);
    int cc;
    bit bwd, rng, known, hit;
    int pops;
    logic [31:0] eip;
    string tag;
    cc = int'(op[3:0]);
    bwd = op[4];
    rng = bwd ? (c < 0 && c >= -MAXS) : (c > 0 && c <= MAXS);
    known = 1; hit = 0; pops = 0;
    case (cc)
      0: begin hit = cy; pops = 0; tag = "R3"; end
      1: begin hit = !cy; pops = 0; tag = "R3"; end
      2: begin hit = t != 0; pops = 1; tag = "R4"; end
      3: begin hit = t == 0; pops = 1; tag = "R4"; end
      4: begin hit = $signed(t) < 0; pops = 1; tag = "R5"; end
      5: begin hit = $signed(t) >= 0; pops = 1; tag = "R5"; end
      6: begin hit = $signed(n) == $signed(t); pops = 2; tag = "R6"; end
      7: begin hit = $signed(n) < $signed(t); pops = 2; tag = "R6"; end
      8: begin hit = $signed(n) <= $signed(t); pops = 2; tag = "R6"; end
      9: begin hit = $signed(n) > $signed(t); pops = 2; tag = "R6"; end
      10: begin hit = $signed(n) >= $signed(t); pops = 2; tag = "R6"; end
      default: begin known = 0; tag = "R11"; end
    endcase
    if (known && !rng) tag = bwd ? "R10" : "R9";
    if (!(known && rng)) begin hit = 0; pops = 0; end
    eip = a + 32'd2 + (hit ? 32'(c) : 32'd0);
    opcode = op; count = 18'(c); ip = a; tos = t; nos = n; carry = cy; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk(hit ? {tag, "/R7"} : {tag, "/R8"},
        {27'd0, out_valid, next_ip, taken, pop_cnt, illegal},
        {27'd0, 1'b1, eip, hit, 2'(pops), !(known && rng)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold_ip;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {out_valid, taken, pop_cnt, illegal, next_ip}, 37'd0);
    rst = 0;
    @(negedge clk);
    for (int op = 0; op < 32; op++)
      for (int ti = 0; ti < 6; ti++)
        for (int ni = 0; ni < 6; ni++)
          for (int cy = 0; cy < 2; cy++)
            for (int ci = 0; ci < 9; ci++)
              issue_and_check(5'(op), pickc(ci), 32'h1000 + 32'(op * 16 + ci), pickv(ti), pickv(ni), cy[0]);
    // R7: address wrap on backward skip near zero
    issue_and_check(5'h10, -MAXS, 32'd3, 32'd0, 32'd0, 1'b1);
    hold_ip = next_ip;
    // R2: idle cycles keep values and drop the strobe
    repeat (2) @(negedge clk);
    chk("R2 idle strobe", {63'd0, out_valid}, 64'd0);
    chk("R2 hold", {32'd0, next_ip}, {32'd0, hold_ip});
    chk("R2 hold flags", {60'd0, taken, pop_cnt, illegal}, {60'd0, 1'b1, 2'd0, 1'b0});
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule